// File: doc/BRIEF.md
# Ternary bug-pattern state matcher

This block watches a vector of critical pipeline control signals and compares it, every cycle, with a small programmable table of ternary patterns. Each pattern describes a control-state configuration that is known to expose a design bug. Software can load these patterns after fabrication. Each entry is a value/mask pair with a valid flag. A mask bit of 1 makes the bit fixed, so the monitored bit must equal the value bit. A mask bit of 0 makes the bit a wildcard that accepts either level.

A hit is registered and reported with the index of the lowest-numbered matching entry. The hit drives a small recovery controller. That controller switches the processor into a simplified, verified inner-core mode and raises a one-cycle flush request. It stays in that mode until a programmable number of instructions have retired with no further hit. It then returns to normal operation with a second one-cycle flush.

Top module: `bugpat_guard`

## Requirements
- R1: Entry e matches state S when it is valid and ((S XOR value) AND mask) is zero. A mask bit of 1 is fixed and a mask bit of 0 is a wildcard.
- R2: An entry whose valid flag is 0 never matches, whatever its value and mask.
- R3: When several entries match, hit_idx_o reports the lowest-numbered one. When there is no hit, hit_idx_o is 0.
- R4: hit_o and hit_idx_o reflect the state_i sampled at the previous rising clock edge. The latency is exactly one cycle.
- R5: A write replaces value, mask and valid of one entry together at the clock edge. An entry that is being written in a cycle produces no match in that cycle. The other entries keep matching in that cycle.
- R6: When hit_o is 1 in normal mode, inner_o is 1 from the next edge onward. flush_o is 1 for exactly that first inner cycle.
- R7: In inner mode, each cycle with hit_o = 1 reloads a countdown with hold_cfg_i. Each cycle with no hit and retire_i = 1 lowers a nonzero countdown by one. The mode is left at the first edge at which the countdown is 0 and hit_o is 0. With hold_cfg_i = 0, it is left at the edge after the last hit.
- R8: On leaving inner mode, inner_o falls and flush_o is 1 for exactly that one cycle.
- R9: Reset clears every entry to invalid and drives hit_o, hit_idx_o, inner_o and flush_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| state_i | input | STATE_W | Monitored control-signal vector |
| retire_i | input | 1 | One instruction retired this cycle |
| hold_cfg_i | input | CNT_W | Retire count to hold inner mode after the last hit |
| wr_en_i | input | 1 | Write one table entry at this edge |
| wr_idx_i | input | IDX_W | Entry number to write |
| wr_value_i | input | STATE_W | Pattern value |
| wr_mask_i | input | STATE_W | Pattern mask, 1 = fixed bit, 0 = wildcard |
| wr_valid_i | input | 1 | Valid flag for the written entry |
| hit_o | output | 1 | Registered match flag |
| hit_idx_o | output | IDX_W | Lowest matching entry, 0 when no hit |
| inner_o | output | 1 | Inner-core mode active |
| flush_o | output | 1 | One-cycle flush request on mode entry or exit |

## Verification
The match path is tried with the following state patterns:
- States that differ from a pattern only in its wildcard bits, which must hit.
- States that differ in a single fixed bit, which must miss.
- A state that fits an entry whose valid flag is clear, which must miss.
- A state that fits two entries at once, which separates the lowest-index priority from any other order.

A write to an entry is issued in the same cycle as a state that matches that entry, while a different entry also matches. This separates exclusion of the written entry alone from blocking the whole table.

Hit trains broken by runs of retire pulses are applied with several hold counts, including zero. These show whether a hit reloads the countdown and whether the exit waits for the full count with no further hit.

// File: rtl/bugpat_pkg.sv
package bugpat_pkg;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_INNER  = 1'b1
    } mode_e;

endpackage

// File: rtl/bugpat_table.sv
module bugpat_table #(
    parameter int STATE_W = 16,
    parameter int ENTRIES = 16,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic [STATE_W-1:0]                wr_value,
    input  logic [STATE_W-1:0]                wr_mask,
    input  logic                              wr_valid,
    output logic [ENTRIES-1:0][STATE_W-1:0]   val_o,
    output logic [ENTRIES-1:0][STATE_W-1:0]   msk_o,
    output logic [ENTRIES-1:0]                vld_o
);

    typedef struct packed {
        logic [ENTRIES-1:0][STATE_W-1:0] val;
        logic [ENTRIES-1:0][STATE_W-1:0] msk;
        logic [ENTRIES-1:0]              vld;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    // The whole entry is replaced in one edge, so no partial pattern is ever visible.
    always_comb begin
        tbl_d = tbl_q;
        if (wr_en) begin
            tbl_d.val[wr_idx] = wr_value;
            tbl_d.msk[wr_idx] = wr_mask;
            tbl_d.vld[wr_idx] = wr_valid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    assign val_o = tbl_q.val;
    assign msk_o = tbl_q.msk;
    assign vld_o = tbl_q.vld;

endmodule

// File: rtl/bugpat_match.sv
module bugpat_match #(
    parameter int STATE_W = 16,
    parameter int ENTRIES = 16,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [STATE_W-1:0]                state,
    input  logic [ENTRIES-1:0][STATE_W-1:0]   val,
    input  logic [ENTRIES-1:0][STATE_W-1:0]   msk,
    input  logic [ENTRIES-1:0]                vld,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_idx,
    output logic                              hit_o,
    output logic [IDX_W-1:0]                  idx_o
);

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } res_t;

    res_t                res_d, res_q;
    logic [ENTRIES-1:0]  raw;

    // One ternary comparator per entry; an entry under write is masked off.
    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        logic busy;
        assign busy   = wr_en && (wr_idx == IDX_W'(e));
        assign raw[e] = vld[e] && !busy && (((state ^ val[e]) & msk[e]) == '0);
    end

    // Scan from the top so the lowest matching index is the one left.
    always_comb begin
        res_d = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (raw[i]) begin
                res_d.hit = 1'b1;
                res_d.idx = IDX_W'(i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign hit_o = res_q.hit;
    assign idx_o = res_q.idx;

endmodule

// File: rtl/bugpat_mode.sv
module bugpat_mode
    import bugpat_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             retire,
    input  logic [CNT_W-1:0] hold_cfg,
    output logic             inner_o,
    output logic             flush_o
);

    typedef struct packed {
        mode_e            mode;
        logic [CNT_W-1:0] cnt;
        logic             flush;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.flush = 1'b0;
        unique case (ctl_q.mode)
            MODE_NORMAL: begin
                if (hit) begin
                    ctl_d.mode  = MODE_INNER;
                    ctl_d.cnt   = hold_cfg;
                    ctl_d.flush = 1'b1;
                end
            end
            MODE_INNER: begin
                if (hit) begin
                    ctl_d.cnt = hold_cfg;
                end else if (ctl_q.cnt == '0) begin
                    ctl_d.mode  = MODE_NORMAL;
                    ctl_d.flush = 1'b1;
                end else if (retire) begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            default: ctl_d = ctl_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{mode: MODE_NORMAL, cnt: '0, flush: 1'b0};
        else        ctl_q <= ctl_d;
    end

    assign inner_o = (ctl_q.mode == MODE_INNER);
    assign flush_o = ctl_q.flush;

endmodule

// File: rtl/bugpat_guard.sv
module bugpat_guard #(
    parameter int STATE_W = 16,
    parameter int ENTRIES = 16,
    parameter int CNT_W   = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STATE_W-1:0] state_i,
    input  logic               retire_i,
    input  logic [CNT_W-1:0]   hold_cfg_i,
    input  logic               wr_en_i,
    input  logic [IDX_W-1:0]   wr_idx_i,
    input  logic [STATE_W-1:0] wr_value_i,
    input  logic [STATE_W-1:0] wr_mask_i,
    input  logic               wr_valid_i,
    output logic               hit_o,
    output logic [IDX_W-1:0]   hit_idx_o,
    output logic               inner_o,
    output logic               flush_o
);

    logic [ENTRIES-1:0][STATE_W-1:0] tbl_val;
    logic [ENTRIES-1:0][STATE_W-1:0] tbl_msk;
    logic [ENTRIES-1:0]              tbl_vld;
    logic                            m_hit;
    logic [IDX_W-1:0]                m_idx;

    bugpat_table #(.STATE_W(STATE_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en_i),
        .wr_idx   (wr_idx_i),
        .wr_value (wr_value_i),
        .wr_mask  (wr_mask_i),
        .wr_valid (wr_valid_i),
        .val_o    (tbl_val),
        .msk_o    (tbl_msk),
        .vld_o    (tbl_vld)
    );

    bugpat_match #(.STATE_W(STATE_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_match (
        .clk    (clk),
        .rst_n  (rst_n),
        .state  (state_i),
        .val    (tbl_val),
        .msk    (tbl_msk),
        .vld    (tbl_vld),
        .wr_en  (wr_en_i),
        .wr_idx (wr_idx_i),
        .hit_o  (m_hit),
        .idx_o  (m_idx)
    );

    bugpat_mode #(.CNT_W(CNT_W)) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (m_hit),
        .retire   (retire_i),
        .hold_cfg (hold_cfg_i),
        .inner_o  (inner_o),
        .flush_o  (flush_o)
    );

    assign hit_o     = m_hit;
    assign hit_idx_o = m_idx;

endmodule

// File: rtl/bugpat_guard_chk.sv
module bugpat_guard_chk #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hit_o,
    input logic [IDX_W-1:0] hit_idx_o,
    input logic             inner_o,
    input logic             flush_o
);

    // R3: index rests at 0 while nothing matches
    p_idx_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> hit_idx_o == '0);

    // R6: a hit seen in normal mode moves the block into inner mode
    p_enter_on_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!inner_o && hit_o) |=> inner_o);

    // R6: entering inner mode comes with a flush
    p_flush_on_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inner_o) |-> flush_o);

    // R8: leaving inner mode comes with a flush
    p_flush_on_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(inner_o) |-> flush_o);

    // R6, R8: a flush only appears in the cycle the mode changed
    p_flush_only_on_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> (inner_o != $past(inner_o)));

    // R7: a hit in inner mode keeps it there
    p_hit_holds_inner_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (inner_o && hit_o) |=> inner_o);

    // R7: exit only follows a cycle without a hit
    p_exit_needs_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(inner_o) |-> !$past(hit_o));

endmodule

bind bugpat_guard bugpat_guard_chk #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_o     (hit_o),
    .hit_idx_o (hit_idx_o),
    .inner_o   (inner_o),
    .flush_o   (flush_o)
);

// File: tb/sim_bugpat_guard.sv
`timescale 1ns/1ps
module sim_bugpat_guard;

    localparam int SW = 16;
    localparam int NE = 16;
    localparam int CW = 8;
    localparam int IW = $clog2(NE);
    localparam int EXP_W = IW + 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [SW-1:0] state_i = '0;
    logic          retire_i = 1'b0;
    logic [CW-1:0] hold_cfg_i = '0;
    logic          wr_en_i = 1'b0;
    logic [IW-1:0] wr_idx_i = '0;
    logic [SW-1:0] wr_value_i = '0;
    logic [SW-1:0] wr_mask_i = '0;
    logic          wr_valid_i = 1'b0;
    logic          hit_o;
    logic [IW-1:0] hit_idx_o;
    logic          inner_o;
    logic          flush_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    bugpat_guard #(.STATE_W(SW), .ENTRIES(NE), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .state_i(state_i), .retire_i(retire_i),
        .hold_cfg_i(hold_cfg_i), .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i),
        .wr_value_i(wr_value_i), .wr_mask_i(wr_mask_i), .wr_valid_i(wr_valid_i),
        .hit_o(hit_o), .hit_idx_o(hit_idx_o), .inner_o(inner_o), .flush_o(flush_o)
    );

    // Reference model built from the requirements
    logic [SW-1:0] r_val [NE];
    logic [SW-1:0] r_msk [NE];
    logic          r_vld [NE];
    logic          r_hit = 1'b0;
    logic [IW-1:0] r_idx = '0;
    logic          r_inner = 1'b0;
    logic          r_flush = 1'b0;
    int            r_cnt = 0;

    logic [EXP_W-1:0] exp_q [$];
    string            tag_q [$];

    task automatic model_edge();
        logic          nh = 1'b0;
        logic [IW-1:0] ni = '0;
        // R1, R2, R3, R5: lowest valid, non-written, ternary-equal entry
        for (int i = NE - 1; i >= 0; i--) begin
            if (r_vld[i] && (((state_i ^ r_val[i]) & r_msk[i]) == '0) &&
                !(wr_en_i && wr_idx_i == IW'(i))) begin
                nh = 1'b1;
                ni = IW'(i);
            end
        end
        // R6, R7, R8: mode follows the previous registered hit
        r_flush = 1'b0;
        if (!r_inner) begin
            if (r_hit) begin
                r_inner = 1'b1; r_flush = 1'b1; r_cnt = int'(hold_cfg_i);
            end
        end else begin
            if (r_hit) r_cnt = int'(hold_cfg_i);
            else if (r_cnt == 0) begin r_inner = 1'b0; r_flush = 1'b1; end
            else if (retire_i) r_cnt = r_cnt - 1;
        end
        if (wr_en_i) begin
            r_val[wr_idx_i] = wr_value_i;
            r_msk[wr_idx_i] = wr_mask_i;
            r_vld[wr_idx_i] = wr_valid_i;
        end
        r_hit = nh;
        r_idx = ni;
    endtask

    // Driver: inputs are set by the caller, one clock edge is modelled and queued
    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        exp_q.push_back({r_hit, r_idx, r_inner, r_flush});
        tag_q.push_back(tag);
        #1;
        wr_en_i = 1'b0;
    endtask

    task automatic put(input int idx, input logic [SW-1:0] v,
                       input logic [SW-1:0] m, input logic ok);
        wr_en_i = 1'b1; wr_idx_i = IW'(idx);
        wr_value_i = v; wr_mask_i = m; wr_valid_i = ok;
    endtask

    // Monitor: compares design outputs with the queued expectations mid-cycle
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [EXP_W-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_checks++;
            if ({hit_o, hit_idx_o, inner_o, flush_o} !== e) begin
                n_fail++;
                $display("FAIL %s: got hit=%0b idx=%0d inner=%0b flush=%0b, want hit=%0b idx=%0d inner=%0b flush=%0b",
                         t, hit_o, hit_idx_o, inner_o, flush_o,
                         e[EXP_W-1], e[IW+1:2], e[1], e[0]);
            end
        end
    end

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: got timeout, want completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NE; i++) begin
            r_val[i] = '0; r_msk[i] = '0; r_vld[i] = 1'b0;
        end
        // R9: outputs cleared under reset
        repeat (3) @(negedge clk);
        n_checks++;
        if ({hit_o, hit_idx_o, inner_o, flush_o} !== '0) begin
            n_fail++;
            $display("FAIL R9: got %0b%0d%0b%0b, want all zero", hit_o, hit_idx_o, inner_o, flush_o);
        end
        @(posedge clk); #1;
        rst_n = 1'b1;
        hold_cfg_i = 8'd2;

        // R9: empty table after reset, nothing matches a zero state
        step("R9 empty table");
        // R5: load entry 3, high byte fixed to A5, low byte wildcard
        put(3, 16'hA500, 16'hFF00, 1'b1); state_i = 16'h0000;
        step("R5 load entry");
        // R1: wildcard low bits accepted
        state_i = 16'hA512;
        step("R1 wildcard hit");
        // R4: single-cycle state, result one cycle later only
        state_i = 16'h1234;
        step("R4 latency, R6 entry flush");
        retire_i = 1'b1;
        for (int k = 0; k < 5; k++) step("R7 hold countdown, R8 exit flush");
        retire_i = 1'b0;
        // R1: one fixed bit off must miss
        state_i = 16'hA412;
        step("R1 fixed bit miss");
        state_i = 16'hA5FF;
        step("R1 all wildcards set");
        state_i = 16'h0000;
        retire_i = 1'b1;
        for (int k = 0; k < 5; k++) step("R7 R8 exit");
        retire_i = 1'b0;

        // R2: invalid entry never matches
        put(1, 16'h00F0, 16'hFFFF, 1'b0);
        step("R2 write invalid");
        state_i = 16'h00F0;
        step("R2 invalid no hit");
        step("R2 invalid no hit");

        // R3: entry 7 matches everything, entry 3 has priority
        put(7, 16'h0000, 16'h0000, 1'b1);
        step("R3 load wide entry");
        state_i = 16'hA500;
        step("R3 lowest index");
        step("R3 lowest index");
        // R5: entry 3 under write drops out, entry 7 still reported
        put(3, 16'hA500, 16'hFF00, 1'b0);
        step("R5 written entry excluded");
        step("R3 remaining entry");
        // R5: only matching entry under write gives no hit
        state_i = 16'h0000;
        put(7, 16'hFFFF, 16'hFFFF, 1'b1);
        step("R5 sole match under write");
        step("R5 new pattern misses");
        state_i = 16'hFFFF;
        step("R5 new pattern hits");
        state_i = 16'h0000;

        // R7: hits during inner mode reload the hold count
        hold_cfg_i = 8'd3;
        retire_i = 1'b1;
        for (int k = 0; k < 3; k++) step("R7 countdown");
        state_i = 16'hFFFF;
        step("R7 reload");
        state_i = 16'h0000;
        for (int k = 0; k < 2; k++) step("R7 countdown");
        retire_i = 1'b0;
        for (int k = 0; k < 3; k++) step("R7 no retire holds");
        retire_i = 1'b1;
        for (int k = 0; k < 5; k++) step("R7 R8 exit after count");

        // R7: hold of zero leaves right after the last hit
        hold_cfg_i = 8'd0;
        retire_i = 1'b0;
        state_i = 16'hFFFF;
        step("R7 zero hold hit");
        state_i = 16'h0000;
        for (int k = 0; k < 4; k++) step("R7 zero hold exit, R8 flush");

        @(negedge clk); @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule